// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block sits between a simple byte requester and an asynchronous DRAM of 16,384 rows by 2,048 bytes. A request carries a 25-bit byte address, a direction and a write byte. The controller splits the address into a row part and a column part and sends both over one 14-bit address bus, one after the other. The DRAM latches the row on the falling edge of an active-low row strobe and the column on the falling edge of an active-low column strobe. Each phase of the access lasts a set number of clock cycles, given by parameters. After every access the bus returns to an idle state and waits out a precharge gap.

Stored charge decays over milliseconds, so the controller also runs its own refresh schedule. An interval timer marks a refresh as due. A refresh cycle activates one row with the column strobe held high, and a counter steps through the rows in ascending order. A due refresh wins over a waiting request, but it never cuts into an access that has already started. The requester sees a ready level and a one-cycle done pulse. For reads, the data is on `rdata_o` at the time of that pulse.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While `rst_ni` is low, all strobes and chip select are high, `dram_addr_o` is 0, `dram_dq_oe_o` and `done_o` are low, and `ready_o` is high.
- R2: The row is byte address bits [24:11] and appears on the full bus. The column is bits [10:0], zero-extended to 14 bits. Outside strobe phases the bus reads 0.
- R3: An access runs these phases in order: row on bus with strobes high (T_ASU cycles), row strobe low (T_RCD), column on bus (T_CSU), column strobe low (T_CAS), then all strobes high (T_RP). Chip select is low from the first phase up to the end of the column strobe.
- R4: The column strobe is low only while the row strobe is low. The bus value does not change on the cycle in which the row strobe falls.
- R5: A write drives `dram_we_no` low and `dram_dq_oe_o` high, with the request byte on `dram_dq_o`, only during the column-strobe phase. A read keeps both inactive.
- R6: A read captures `dram_dq_i` on the last column-strobe cycle and holds it on `rdata_o` until the next read completes.
- R7: `done_o` is high for exactly one cycle: the cycle after the column-strobe phase ends.
- R8: `ready_o` is high only when the controller is idle and no refresh is due. A request is taken on a clock edge where both `req_i` and `ready_o` are high.
- R9: A refresh becomes due every REF_INTERVAL cycles after reset. With no traffic, the first refresh phase is visible in cycle REF_INTERVAL+1.
- R10: When a refresh is due while idle, it starts before any waiting request. A refresh that falls due during an access waits until that access and its precharge are over.
- R11: A refresh cycle puts the refresh row on the bus with strobes high for T_ASU cycles, then holds the row strobe low for T_REF_RAS cycles, then precharges for T_RP. The column strobe and write enable stay high throughout.
- R12: Refresh rows start at 0 after reset and go up by one per refresh, modulo 16,384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 25 | Byte address (row in [24:11], column in [10:0]) |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Controller can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last read byte |
| dram_addr_o | output | 14 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_cs_no | output | 1 | Chip select, active low |
| dram_dq_o | output | 8 | Write data to the DRAM |
| dram_dq_oe_o | output | 1 | Data output enable |
| dram_dq_i | input | 8 | Read data from the DRAM |

## Verification
If the phase counter or state is wrong, a strobe edge moves or a phase is missing. That shows on the pins in the same cycle, because every pin is decoded straight from the registered phase. A wrong refresh timer or row counter shows as a refresh that starts in the wrong cycle, or as a wrong row on the bus, the first time a refresh runs. A corrupted address latch or data capture shows only at the next access or read completion. The reference model checks every pin on every cycle, and it carries a pin-level memory, so a write to one address followed by a read from it brings such faults out.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE,
    ST_RROW,
    ST_RRAS
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mux_dram_refresh.sv
module mux_dram_refresh #(
  parameter int ROW_W    = 14,
  parameter int INTERVAL = 975
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = $clog2(INTERVAL);

  logic [TW-1:0] timer_q;
  logic          wrap;

  assign wrap = (timer_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      pend_o  <= 1'b0;
      row_o   <= '0;
    end else begin
      timer_q <= wrap ? '0 : timer_q + 1'b1;
      // a new due mark outranks the clear
      if (wrap)         pend_o <= 1'b1;
      else if (start_i) pend_o <= 1'b0;
      if (step_i) row_o <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/mux_dram_seq.sv
module mux_dram_seq
  import mux_dram_pkg::*;
#(
  parameter int T_ASU     = 1,
  parameter int T_RCD     = 2,
  parameter int T_CSU     = 1,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_REF_RAS = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   ref_pend_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   ref_start_o,
  output logic   ref_step_o,
  output logic   cas_end_o
);
  localparam int MAX_T = max_int(max_int(max_int(T_ASU, T_RCD), max_int(T_CSU, T_CAS)),
                                 max_int(T_RP, T_REF_RAS));
  localparam int CW = $clog2(MAX_T + 1);

  logic [CW-1:0] cnt_q;
  phase_e        nxt;
  logic          last;

  function automatic logic [CW-1:0] len_m1(input phase_e p);
    case (p)
      ST_ROW, ST_RROW: return CW'(T_ASU - 1);
      ST_RAS:          return CW'(T_RCD - 1);
      ST_COL:          return CW'(T_CSU - 1);
      ST_CAS:          return CW'(T_CAS - 1);
      ST_PRE:          return CW'(T_RP - 1);
      ST_RRAS:         return CW'(T_REF_RAS - 1);
      default:         return '0;
    endcase
  endfunction

  assign last = (cnt_q == '0);

  always_comb begin
    nxt = phase_o;
    case (phase_o)
      ST_IDLE: begin
        if (ref_pend_i) nxt = ST_RROW;
        else if (req_i) nxt = ST_ROW;
      end
      ST_ROW:  if (last) nxt = ST_RAS;
      ST_RAS:  if (last) nxt = ST_COL;
      ST_COL:  if (last) nxt = ST_CAS;
      ST_CAS:  if (last) nxt = ST_PRE;
      ST_PRE:  if (last) nxt = ST_IDLE;
      ST_RROW: if (last) nxt = ST_RRAS;
      ST_RRAS: if (last) nxt = ST_PRE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_o <= nxt;
      if (nxt != phase_o) cnt_q <= len_m1(nxt);
      else if (!last)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign accept_o    = (phase_o == ST_IDLE) && !ref_pend_i && req_i;
  assign ref_start_o = (phase_o == ST_IDLE) && ref_pend_i;
  assign ref_step_o  = (phase_o == ST_RRAS) && last;
  assign cas_end_o   = (phase_o == ST_CAS) && last;
endmodule

// File: rtl/mux_dram_pins.sv
module mux_dram_pins
  import mux_dram_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 11,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 14
) (
  input  phase_e            phase_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BUS_W-1:0]  addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic              cs_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  always_comb begin
    addr_o  = '0;
    ras_no  = 1'b1;
    cas_no  = 1'b1;
    we_no   = 1'b1;
    cs_no   = 1'b1;
    dq_oe_o = 1'b0;
    dq_o    = '0;
    case (phase_i)
      ST_ROW: begin
        addr_o = BUS_W'(row_i);
        cs_no  = 1'b0;
      end
      ST_RAS: begin
        addr_o = BUS_W'(row_i);
        cs_no  = 1'b0;
        ras_no = 1'b0;
      end
      ST_COL: begin
        addr_o = BUS_W'(col_i);
        cs_no  = 1'b0;
        ras_no = 1'b0;
      end
      ST_CAS: begin
        addr_o  = BUS_W'(col_i);
        cs_no   = 1'b0;
        ras_no  = 1'b0;
        cas_no  = 1'b0;
        we_no   = !wr_i;
        dq_oe_o = wr_i;
        dq_o    = wr_i ? wdata_i : '0;
      end
      ST_RROW: begin
        addr_o = BUS_W'(ref_row_i);
        cs_no  = 1'b0;
      end
      ST_RRAS: begin
        addr_o = BUS_W'(ref_row_i);
        cs_no  = 1'b0;
        ras_no = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mux_dram_pkg::*;
#(
  parameter int ROW_W        = 14,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 8,
  parameter int T_ASU        = 1,
  parameter int T_RCD        = 2,
  parameter int T_CSU        = 1,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int T_REF_RAS    = 3,
  parameter int REF_INTERVAL = 975
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic                   ready_o,
  output logic                   done_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                   dram_ras_no,
  output logic                   dram_cas_no,
  output logic                   dram_we_no,
  output logic                   dram_cs_no,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int AW    = ROW_W + COL_W;

  phase_e            phase;
  logic              ref_pend, accept, ref_start, ref_step, cas_end;
  logic [AW-1:0]     addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ROW_W-1:0]  ref_row;

  mux_dram_refresh #(
    .ROW_W   (ROW_W),
    .INTERVAL(REF_INTERVAL)
  ) i_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ref_start),
    .step_i (ref_step),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  mux_dram_seq #(
    .T_ASU    (T_ASU),
    .T_RCD    (T_RCD),
    .T_CSU    (T_CSU),
    .T_CAS    (T_CAS),
    .T_RP     (T_RP),
    .T_REF_RAS(T_REF_RAS)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ref_pend_i (ref_pend),
    .phase_o    (phase),
    .accept_o   (accept),
    .ref_start_o(ref_start),
    .ref_step_o (ref_step),
    .cas_end_o  (cas_end)
  );

  mux_dram_pins #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .BUS_W (BUS_W)
  ) i_pins (
    .phase_i  (phase),
    .row_i    (addr_q[AW-1:COL_W]),
    .col_i    (addr_q[COL_W-1:0]),
    .ref_row_i(ref_row),
    .wr_i     (wr_q),
    .wdata_i  (wdata_q),
    .addr_o   (dram_addr_o),
    .ras_no   (dram_ras_no),
    .cas_no   (dram_cas_no),
    .we_no    (dram_we_no),
    .cs_no    (dram_cs_no),
    .dq_o     (dram_dq_o),
    .dq_oe_o  (dram_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wr_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (cas_end && !wr_q) rdata_o <= dram_dq_i;
      done_o <= cas_end;
    end
  end

  assign ready_o = (phase == ST_IDLE) && !ref_pend;
endmodule

// File: rtl/mux_dram_chk.sv
module mux_dram_chk #(
  parameter int BUS_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cs_n,
  input logic             dq_oe,
  input logic [BUS_W-1:0] addr,
  input logic             done,
  input logic             ready
);
  // R4
  cas_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n |-> !ras_n);

  // R4
  row_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> $stable(addr));

  // R5
  we_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n |-> (!cas_n && dq_oe));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  // R7
  done_after_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> $past(!cas_n));

  // R8
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (ras_n && cas_n && cs_n));

  // R3
  cs_cover_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n |-> !cs_n);
endmodule

bind mux_dram_ctrl mux_dram_chk #(.BUS_W(BUS_W)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ras_n (dram_ras_no),
  .cas_n (dram_cas_no),
  .we_n  (dram_we_no),
  .cs_n  (dram_cs_no),
  .dq_oe (dram_dq_oe_o),
  .addr  (dram_addr_o),
  .done  (done_o),
  .ready (ready_o)
);

// File: tb/test_mux_dram_ctrl.sv
`timescale 1ns/1ps
module test_mux_dram_ctrl;
  localparam int ASU = 1, RCD = 2, CSU = 1, CAS = 2, RP = 3, REFRAS = 3, INTV = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [24:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o, done_o;
  logic [7:0]  rdata_o;
  logic [13:0] d_addr;
  logic        ras_n, cas_n, we_n, cs_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mux_dram_ctrl #(
    .T_ASU(ASU), .T_RCD(RCD), .T_CSU(CSU), .T_CAS(CAS), .T_RP(RP),
    .T_REF_RAS(REFRAS), .REF_INTERVAL(INTV)
  ) i_mux_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .dram_addr_o(d_addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_cs_no(cs_n), .dram_dq_o(dq_o),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return k[7:0] ^ k[15:8] ^ k[23:16] ^ 8'h5A;
  endfunction

  // pin-level DRAM
  logic [7:0]  pin_mem [int];
  logic [13:0] row_l = '0;
  function automatic logic [7:0] pin_rd(input int k);
    return pin_mem.exists(k) ? pin_mem[k] : pat(k);
  endfunction
  always @(posedge clk) begin
    if (ras_n) row_l <= d_addr;
    if (!cas_n && !we_n && dq_oe) pin_mem[int'({row_l, d_addr[10:0]})] = dq_o;
  end
  assign dq_i = (!cas_n && we_n) ? pin_rd(int'({row_l, d_addr[10:0]})) : 8'h00;

  // reference model: 0 idle 1 row 2 ras 3 col 4 cas 5 pre 6 rrow 7 rras
  logic [7:0] exp_mem [int];
  int m_ph = 0, m_rem = 1, m_timer = 0, m_refrow = 0, cyc = 0;
  bit m_pend = 0, m_done = 0, m_we = 0, m_wrap, m_start;
  logic [24:0] m_a = '0;
  logic [7:0] m_wd = '0, m_rd = '0;

  function automatic int plen(input int p);
    case (p)
      1, 6: return ASU;
      2: return RCD;
      3: return CSU;
      4: return CAS;
      5: return RP;
      7: return REFRAS;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 1; m_timer = 0; m_refrow = 0; m_pend = 0;
      m_done = 0; m_rd = '0; cyc = 0;
    end else begin
      cyc++;
      m_wrap = (m_timer == INTV - 1);
      m_start = 0;
      m_done = 0;
      if (m_ph == 0) begin
        if (m_pend) begin
          m_start = 1; m_ph = 6; m_rem = plen(6);
        end else if (req) begin
          m_a = addr; m_we = we; m_wd = wdata; m_ph = 1; m_rem = plen(1);
        end
      end else if (m_rem > 1) begin
        m_rem--;
      end else begin
        case (m_ph)
          4: begin
            m_done = 1;
            if (m_we) exp_mem[int'(m_a)] = m_wd;
            else m_rd = exp_mem.exists(int'(m_a)) ? exp_mem[int'(m_a)] : pat(int'(m_a));
            m_ph = 5;
          end
          5: m_ph = 0;
          7: begin m_refrow = (m_refrow + 1) % 16384; m_ph = 5; end
          default: m_ph = m_ph + 1;
        endcase
        m_rem = plen(m_ph);
      end
      m_pend = m_wrap ? 1'b1 : (m_start ? 1'b0 : m_pend);
      m_timer = m_wrap ? 0 : m_timer + 1;
    end
  end

  // per-cycle comparison
  int first_ref = -1, contention = 0, ref_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic logic [13:0] e_addr = '0;
      automatic bit rf = (m_ph >= 6);
      automatic bit e_ras = !(m_ph inside {2, 3, 4, 7});
      automatic bit e_cas = (m_ph != 4);
      automatic bit e_wr = (m_ph == 4) && m_we;
      automatic bit e_cs = !(m_ph inside {1, 2, 3, 4, 6, 7});
      case (m_ph)
        1, 2: e_addr = m_a[24:11];
        3, 4: e_addr = {3'b000, m_a[10:0]};
        6, 7: e_addr = 14'(m_refrow);
        default: e_addr = '0;
      endcase
      check(d_addr == e_addr, rf ? "R11" : "R2", "bus", d_addr, e_addr);
      check(ras_n == e_ras, rf ? "R11" : "R3", "ras_n", ras_n, e_ras);
      check(cas_n == e_cas, rf ? "R11" : "R3", "cas_n", cas_n, e_cas);
      check(cs_n == e_cs, "R3", "cs_n", cs_n, e_cs);
      check(we_n == !e_wr, "R5", "we_n", we_n, !e_wr);
      check(dq_oe == e_wr, "R5", "dq_oe", dq_oe, e_wr);
      if (e_wr) check(dq_o == m_wd, "R5", "dq_o", dq_o, m_wd);
      check(cas_n || !ras_n, "R4", "cas without ras", cas_n, 1);
      check(done_o == m_done, "R7", "done", done_o, m_done);
      check(ready_o == (m_ph == 0 && !m_pend), "R8", "ready", ready_o, (m_ph == 0 && !m_pend));
      check(rdata_o == m_rd, "R6", "rdata", rdata_o, m_rd);
      if (m_ph == 6 && first_ref < 0) first_ref = cyc;
      if (req && m_ph == 0 && m_pend) begin
        contention++;
        check(!ready_o, "R10", "ready during due refresh", ready_o, 0);
      end
      if (m_ph == 7 && m_rem == REFRAS) begin
        check(d_addr == 14'(ref_seen), "R12", "refresh row order", d_addr, ref_seen);
        ref_seen++;
      end
    end
  end

  task automatic access(input bit w, input logic [24:0] a, input logic [7:0] d,
                        input bit chk_rd, input logic [7:0] exp);
    bit taken = 0;
    @(posedge clk); #1;
    req = 1'b1; we = w; addr = a; wdata = d;
    while (!taken) begin
      @(negedge clk);
      if (ready_o) begin
        @(posedge clk); #1;
        req = 1'b0;
        taken = 1;
      end
    end
    do @(negedge clk); while (!done_o);
    if (chk_rd) check(rdata_o == exp, "R6", "read-back", rdata_o, exp);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && cs_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, cs_n, we_n}, 4'hF);
    check(d_addr == 0 && !dq_oe && !done_o, "R1", "bus/done in reset", d_addr, 0);
    check(ready_o, "R1", "ready in reset", ready_o, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    // R9 first refresh with no traffic
    repeat (INTV + 8) @(posedge clk);
    check(first_ref == INTV + 1, "R9", "first refresh cycle", first_ref, INTV + 1);
    access(1'b1, 25'h1234567, 8'hA5, 0, 0);
    access(1'b0, 25'h1234567, 8'h00, 1, 8'hA5);
    access(1'b0, 25'h0ABCDEF, 8'h00, 1, pat(int'(25'h0ABCDEF)));
    access(1'b1, 25'h1FFFFFF, 8'h3C, 0, 0);
    access(1'b1, 25'h0000000, 8'hC3, 0, 0);
    access(1'b0, 25'h1FFFFFF, 8'h00, 1, 8'h3C);
    access(1'b0, 25'h0000000, 8'h00, 1, 8'hC3);
    for (int i = 0; i < 40; i++) begin
      automatic logic [24:0] a = 25'((i * 32'h0012_3457) ^ (i << 11));
      access(1'b1, a, 8'(i * 7 + 1), 0, 0);
      access(1'b0, a, 8'h00, 1, 8'(i * 7 + 1));
    end
    repeat (20) @(posedge clk);
    check(contention > 0, "R10", "refresh beat waiting request", contention, 1);
    check(ref_seen >= 8, "R12", "refreshes observed", ref_seen, 8);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule